// File: doc/BRIEF.md
# Bitfield Extract and Vector Shift Unit

This block is a 32-bit shifter. It handles three kinds of operation. The first pulls a bit field out of a word, with either zero fill or sign fill above the field. The second joins two words and takes a 32-bit window from the join at a byte offset of 1, 2 or 3. The third shifts the two 16-bit halves of a word, each on its own: arithmetic, logical or saturating.

A caller presents two data words, a 16-bit control word and a 3-bit opcode, and pulses `op_valid`. One clock later the unit shows the result, a zero flag, a negative flag and a saturation flag. These outputs keep their values until the next operation arrives.

For an extract, the control word holds both the field length and the field position. For a vector shift, its low bits hold a signed shift count.

Top module: `bitfield_vshift_unit`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `op_valid` is high, and low otherwise. While `op_valid` is low, `result` and all flags keep their values.
- R2: Opcode 3'd0 (zero-fill extract) gives `(src_a >> ctrl[12:8]) & ((1 << ctrl[4:0]) - 1)`.
- R3: A field length `ctrl[4:0]` of 0 gives a result of 0 for both extract opcodes.
- R4: Opcode 3'd1 (sign-fill extract) takes the same field as R2. It copies field bit `ctrl[4:0]-1` into every bit above the field.
- R5: Opcodes 3'd2, 3'd3 and 3'd4 select N = 1, 2 or 3 bytes. They give `(src_b << (32-8N)) | (src_a >> 8N)`.
- R6: Opcodes 3'd5 (arithmetic), 3'd6 (logical) and 3'd7 (saturating) shift `src_a[31:16]` and `src_a[15:0]` on their own, by the signed two's-complement count `ctrl[4:0]` (range -16 to +15). A positive count shifts left and brings in zeros.
- R7: A negative count shifts right by its magnitude. Opcodes 3'd5 and 3'd7 fill with the sign bit of each halfword. Opcode 3'd6 fills with zeros. A count of -16 empties the halfword completely.
- R8: For opcode 3'd7 with a left shift, a halfword whose signed value does not fit in 16 bits is clamped: to 16'h7FFF when its input was non-negative, and to 16'h8000 when its input was negative.
- R9: `flag_ovf` is 1 only after an opcode 3'd7 operation in which at least one halfword was clamped. After any other opcode it is 0.
- R10: `flag_zero` is 1 exactly when the final 32-bit result is 0. `flag_neg` equals bit 31 of the final result.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| opcode | input | 3 | Operation select (see R2 to R9) |
| src_a | input | 32 | Data word; low word for align |
| src_b | input | 32 | High word for align |
| ctrl | input | 16 | Field length [4:0] and position [12:8], or shift count [4:0] |
| res_valid | output | 1 | Result updated this cycle |
| result | output | 32 | Operation result |
| flag_zero | output | 1 | Result equals zero |
| flag_neg | output | 1 | Result bit 31 |
| flag_ovf | output | 1 | A halfword saturated |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, 16-bit halfword lanes, a 5-bit count and a position field at bit 8. With these values every corner can be reached from a short vector table:
- a field length of 0 and of 31;
- a field at the top of the word;
- counts of -16, -1, 0 and positive values;
- the two clamp directions;
- a left shift that overflows in a non-saturating mode.

// File: rtl/bvs_pkg.sv
package bvs_pkg;

    typedef enum logic [2:0] {
        OP_EXT_ZX    = 3'd0,
        OP_EXT_SX    = 3'd1,
        OP_ALN1      = 3'd2,
        OP_ALN2      = 3'd3,
        OP_ALN3      = 3'd4,
        OP_VSH_ARITH = 3'd5,
        OP_VSH_LOGIC = 3'd6,
        OP_VSH_SAT   = 3'd7
    } bvs_op_e;

    typedef enum logic [1:0] {
        HS_ARITH = 2'd0,
        HS_LOGIC = 2'd1,
        HS_SAT   = 2'd2
    } half_mode_e;

endpackage

// File: rtl/bvs_extract.sv
module bvs_extract #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  pos,
    input  logic              sign_fill,
    output logic [DATA_W-1:0] field
);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] masked;
    logic [LEN_W-1:0]  top_idx;
    logic              top_bit;

    always_comb begin
        shifted   = src >> pos;
        keep_mask = ~({DATA_W{1'b1}} << len);
        masked    = shifted & keep_mask;
        top_idx   = len - 1'b1;
        top_bit   = (len != '0) && shifted[top_idx];
        field     = (sign_fill && top_bit) ? (masked | ~keep_mask) : masked;
    end

endmodule

// File: rtl/bvs_align.sv
module bvs_align #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [1:0]        byte_sel,
    output logic [DATA_W-1:0] window
);

    localparam int BYTE_W = 8;
    localparam int SH_W   = $clog2(DATA_W) + 1;

    logic [2*DATA_W-1:0] joined;
    logic [SH_W-1:0]     bit_off;

    always_comb begin
        bit_off = SH_W'(byte_sel) * SH_W'(BYTE_W);
        joined  = {hi_word, lo_word} >> bit_off;
        window  = joined[DATA_W-1:0];
    end

endmodule

// File: rtl/bvs_half_shift.sv
module bvs_half_shift
    import bvs_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [HALF_W-1:0] val,
    input  logic [CNT_W-1:0]  cnt,
    input  half_mode_e        mode,
    output logic [HALF_W-1:0] res,
    output logic              clamped
);

    localparam int WIDE_W = 2 * HALF_W;

    logic [WIDE_W-1:0]  wide;
    logic [HALF_W:0]    top_part;
    logic               fits;
    logic [CNT_W:0]     cnt_ext;
    logic [CNT_W:0]     rmag;
    logic [HALF_W-1:0]  sat_val;

    always_comb begin
        cnt_ext  = {cnt[CNT_W-1], cnt};
        rmag     = -cnt_ext;
        wide     = {{HALF_W{val[HALF_W-1]}}, val} << cnt[CNT_W-2:0];
        top_part = wide[WIDE_W-1:HALF_W-1];
        fits     = (&top_part) | ~(|top_part);
        sat_val  = val[HALF_W-1] ? {1'b1, {(HALF_W-1){1'b0}}}
                                 : {1'b0, {(HALF_W-1){1'b1}}};
        clamped  = 1'b0;
        if (cnt[CNT_W-1]) begin
            if (mode == HS_LOGIC) res = val >> rmag;
            else                  res = HALF_W'($signed(val) >>> rmag);
        end else if (mode == HS_SAT && !fits) begin
            res     = sat_val;
            clamped = 1'b1;
        end else begin
            res = wide[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/bvs_vshift.sv
module bvs_vshift
    import bvs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    input  half_mode_e        mode,
    output logic [DATA_W-1:0] res,
    output logic              any_clamp
);

    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = DATA_W / HALF_W;

    logic [LANES-1:0] lane_clamp;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bvs_half_shift #(
            .HALF_W (HALF_W),
            .CNT_W  (CNT_W)
        ) u_half (
            .val     (src[g*HALF_W +: HALF_W]),
            .cnt     (cnt),
            .mode    (mode),
            .res     (res[g*HALF_W +: HALF_W]),
            .clamped (lane_clamp[g])
        );
    end

    assign any_clamp = |lane_clamp;

endmodule

// File: rtl/bitfield_vshift_unit.sv
module bitfield_vshift_unit
    import bvs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CTRL_W  = 16,
    parameter int CNT_W   = 5,
    parameter int POS_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_ovf
);

    localparam int LEN_W = $clog2(DATA_W);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              z;
        logic              n;
        logic              v;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic [DATA_W-1:0] ext_res, aln_res, vsh_res;
    logic              vsh_clamp;
    logic [1:0]        aln_sel;
    half_mode_e        vsh_mode;
    bvs_op_e           op;
    logic              unused_ctrl_bits;

    assign op               = bvs_op_e'(opcode);
    assign unused_ctrl_bits = ^{ctrl[CTRL_W-1:POS_LSB+LEN_W], ctrl[POS_LSB-1:LEN_W]};

    always_comb begin
        case (op)
            OP_ALN1: aln_sel = 2'd1;
            OP_ALN2: aln_sel = 2'd2;
            OP_ALN3: aln_sel = 2'd3;
            default: aln_sel = 2'd0;
        endcase
        case (op)
            OP_VSH_LOGIC: vsh_mode = HS_LOGIC;
            OP_VSH_SAT:   vsh_mode = HS_SAT;
            default:      vsh_mode = HS_ARITH;
        endcase
    end

    bvs_extract #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_extract (
        .src       (src_a),
        .len       (ctrl[LEN_W-1:0]),
        .pos       (ctrl[POS_LSB +: LEN_W]),
        .sign_fill (op == OP_EXT_SX),
        .field     (ext_res)
    );

    bvs_align #(
        .DATA_W (DATA_W)
    ) u_align (
        .lo_word  (src_a),
        .hi_word  (src_b),
        .byte_sel (aln_sel),
        .window   (aln_res)
    );

    bvs_vshift #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_vshift (
        .src       (src_a),
        .cnt       (ctrl[CNT_W-1:0]),
        .mode      (vsh_mode),
        .res       (vsh_res),
        .any_clamp (vsh_clamp)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = op_valid;
        if (op_valid) begin
            case (op)
                OP_EXT_ZX, OP_EXT_SX:           st_d.res = ext_res;
                OP_ALN1, OP_ALN2, OP_ALN3:      st_d.res = aln_res;
                default:                        st_d.res = vsh_res;
            endcase
            st_d.z = (st_d.res == '0);
            st_d.n = st_d.res[DATA_W-1];
            st_d.v = (op == OP_VSH_SAT) && vsh_clamp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_zero = st_q.z;
    assign flag_neg  = st_q.n;
    assign flag_ovf  = st_q.v;

endmodule

// File: rtl/bvs_unit_checker.sv
module bvs_unit_checker #(
    parameter int DATA_W  = 32,
    parameter int CTRL_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        opcode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [CTRL_W-1:0] ctrl,
    input logic              res_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag_zero,
    input logic              flag_neg,
    input logic              flag_ovf
);

    localparam int LEN_W = $clog2(DATA_W);
    localparam int HW    = DATA_W / 2;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(result) && $stable(flag_ovf)));

    assert_zx_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd0) |=> ((result >> $past(ctrl[LEN_W-1:0])) == '0));

    assert_len_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[2:1] == 2'b00 && ctrl[LEN_W-1:0] == '0) |=> (result == '0));

    assert_align16_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 3'd3) |=>
            (result == {$past(src_b[HW-1:0]), $past(src_a[DATA_W-1:HW])}));

    assert_no_ovf_outside_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode != 3'd7) |=> !flag_ovf);

    assert_flags_track_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((flag_zero == (result == '0)) && (flag_neg == result[DATA_W-1])));

endmodule

bind bitfield_vshift_unit bvs_unit_checker #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .src_a     (src_a),
    .src_b     (src_b),
    .ctrl      (ctrl),
    .res_valid (res_valid),
    .result    (result),
    .flag_zero (flag_zero),
    .flag_neg  (flag_neg),
    .flag_ovf  (flag_ovf)
);

// File: tb/bitfield_vshift_unit_bench.sv
`timescale 1ns/100ps
module bitfield_vshift_unit_bench;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] c;
        logic [31:0] exp;
        logic        ovf;
    } vec_t;

    localparam int NV = 21;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'hDEADBEEF, 32'h0, 16'h0408, 32'h000000EE, 1'b0},
        '{3'd1, 32'hDEADBEEF, 32'h0, 16'h0408, 32'hFFFFFFEE, 1'b0},
        '{3'd1, 32'hDEADBEEF, 32'h0, 16'h1C04, 32'hFFFFFFFD, 1'b0},
        '{3'd1, 32'h12345678, 32'h0, 16'h0010, 32'h00005678, 1'b0},
        '{3'd0, 32'hFFFFFFFF, 32'h0, 16'h0300, 32'h00000000, 1'b0},
        '{3'd1, 32'hFFFFFFFF, 32'h0, 16'h0000, 32'h00000000, 1'b0},
        '{3'd0, 32'hFFFFFFFF, 32'h0, 16'h011F, 32'h7FFFFFFF, 1'b0},
        '{3'd2, 32'h11223344, 32'hAABBCCDD, 16'h0, 32'hDD112233, 1'b0},
        '{3'd3, 32'h11223344, 32'hAABBCCDD, 16'h0, 32'hCCDD1122, 1'b0},
        '{3'd4, 32'h11223344, 32'hAABBCCDD, 16'h0, 32'hBBCCDD11, 1'b0},
        '{3'd5, 32'h0003FFF0, 32'h0, 16'h0004, 32'h0030FF00, 1'b0},
        '{3'd5, 32'h80100100, 32'h0, 16'h001C, 32'hF8010010, 1'b0},
        '{3'd6, 32'h80100100, 32'h0, 16'h001C, 32'h08010010, 1'b0},
        '{3'd6, 32'hFFFFFFFF, 32'h0, 16'h0010, 32'h00000000, 1'b0},
        '{3'd5, 32'h80007FFF, 32'h0, 16'h0010, 32'hFFFF0000, 1'b0},
        '{3'd7, 32'h40000001, 32'h0, 16'h0001, 32'h7FFF0002, 1'b1},
        '{3'd7, 32'hC0008000, 32'h0, 16'h0001, 32'h80008000, 1'b1},
        '{3'd7, 32'h1234FFFF, 32'h0, 16'h0000, 32'h1234FFFF, 1'b0},
        '{3'd7, 32'h00FFFF00, 32'h0, 16'h0003, 32'h07F8F800, 1'b0},
        '{3'd7, 32'h80000002, 32'h0, 16'h001F, 32'hC0000001, 1'b0},
        '{3'd5, 32'h40000001, 32'h0, 16'h0001, 32'h80000002, 1'b0}
    };

    localparam string TAGS [NV] = '{
        "R2", "R4", "R4", "R4", "R3", "R3", "R2",
        "R5", "R5", "R5",
        "R6", "R7", "R7", "R7", "R7",
        "R8", "R8", "R9", "R9", "R7", "R9"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] ctrl = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        flag_zero, flag_neg, flag_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bitfield_vshift_unit u_bitfield_vshift_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .src_a     (src_a),
        .src_b     (src_b),
        .ctrl      (ctrl),
        .res_valid (res_valid),
        .result    (result),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .flag_ovf  (flag_ovf)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] c);
        @(negedge clk);
        op_valid = 1'b1;
        opcode   = op;
        src_a    = a;
        src_b    = b;
        ctrl     = c;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: outputs during reset
        repeat (3) @(negedge clk);
        check("R11", "res_valid in reset", {31'b0, res_valid}, 32'h0);
        check("R11", "result in reset", result, 32'h0);
        check("R11", "flags in reset", {29'b0, flag_zero, flag_neg, flag_ovf}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].c);
            check(TAGS[i], "result", result, VECS[i].exp);
            check("R9", "flag_ovf", {31'b0, flag_ovf}, {31'b0, VECS[i].ovf});
            check("R10", "zero/neg flags", {30'b0, flag_zero, flag_neg},
                  {30'b0, VECS[i].exp == 32'h0, VECS[i].exp[31]});
            check("R1", "res_valid after op", {31'b0, res_valid}, 32'h1);
        end

        // R1: idle cycles keep result and flags, valid drops
        issue(3'd7, 32'h40000001, 32'h0, 16'h0001);
        opcode = 3'd0;
        src_a  = 32'h0;
        ctrl   = 16'h0;
        @(negedge clk);
        check("R1", "valid low when idle", {31'b0, res_valid}, 32'h0);
        check("R1", "result held when idle", result, 32'h7FFF0002);
        check("R1", "ovf held when idle", {31'b0, flag_ovf}, 32'h1);

        // R9: a following non-saturating op clears the overflow flag
        issue(3'd6, 32'h40000001, 32'h0, 16'h0001);
        check("R9", "ovf cleared by logical shift", {31'b0, flag_ovf}, 32'h0);
        check("R6", "logical left shift", result, 32'h80000002);

        // R11: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "result after reset", result, 32'h0);
        check("R11", "flag_neg after reset", {31'b0, flag_neg}, 32'h0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule